// File: doc/BRIEF.md
# Fractional Conversion Pacing Divider

This block paces a converter running in continuous mode. It holds a divisor made of an integer part and a fractional part, and it emits a one-cycle `tick` each time a new conversion should start. The mean spacing between ticks is `1 + INT + FRAC/256` clock cycles. The fractional part is realised by first-order delta-sigma dithering: each period is either `1 + INT` or `2 + INT` cycles long, and an 8-bit phase accumulator decides which.

The divisor is loaded through a single write strobe that carries both fields at once. When the whole divisor is zero, `pace_active` is low and no ticks are produced. The sequencer outside this block then runs conversions back-to-back. Any divisor write, and any cycle with continuous mode off, returns the period counter and the phase accumulator to zero. The next pacing sequence therefore always starts from a known phase.

Top module: `pace_div`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `tick` and `pace_active` are both 0, and the stored divisor is zero.
- R2: A cycle with `div_wr` high stores `div_int_in` and `div_frac_in`. From the next cycle on, `pace_active` is 1 exactly when the stored integer or fractional part is nonzero.
- R3: With a stored divisor of zero, `tick` stays 0 even while `cont_en` is high.
- R4: Each period lasts `1 + INT + c` rising edges. `c` is the carry out of adding FRAC to the 8-bit phase accumulator, which then keeps the 8-bit sum. After a restart the accumulator is 0. The first tick appears on the sample after the (INT+1)-th rising edge with `cont_en` high.
- R5: With INT=0 and FRAC=0x80, the tick intervals alternate 1, 2, 1, 2 cycles, starting with 1.
- R6: Over 256 periods starting from a restart, the total span is exactly `256*(1+INT)+FRAC` cycles.
- R7: A divisor write clears `tick` and restarts both the counter and the accumulator. This holds even when the written value equals the stored one. Counting resumes on the edge after the write.
- R8: While `cont_en` is 0, `tick` stays 0. The counter and accumulator are held at zero, so re-enabling starts a fresh sequence.
- R9: The integer part uses the full 16-bit width, so a value such as 1000 gives periods of 1001 cycles.
- R10: When INT is at least 1, `tick` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cont_en | input | 1 | Continuous conversion mode enabled |
| div_wr | input | 1 | Divisor write strobe (loads both fields, restarts pacing) |
| div_int_in | input | 16 | Integer divisor part to store |
| div_frac_in | input | 8 | Fractional divisor part to store, units of 1/256 |
| tick | output | 1 | One-cycle conversion start pulse |
| pace_active | output | 1 | Stored divisor is nonzero, so pacing is in effect |

## Verification
The bench compares every tick position against an independent model of the dither sequence. Off-by-one period lengths, or a carry applied one period late, show up as misplaced ticks. A design that kept the accumulator across a rewrite or across a mode drop would begin with a long period where a short one is due, and the restart and mode-off tests look for exactly that. The 256-period span test catches a carry that is lost or counted twice. A divisor of zero must produce no ticks at all, and a 1000-cycle integer catches a counter that is too narrow.

// File: rtl/pace_div_pkg.sv
package pace_div_pkg;

    localparam int PACE_INT_W_DEF  = 16;
    localparam int PACE_FRAC_W_DEF = 8;

    // Counter behaviour for the current cycle
    typedef enum logic [1:0] {
        PM_CLEAR = 2'd0,   // restart: write strobe or continuous mode off
        PM_HOLD  = 2'd1,   // divisor zero: nothing to pace
        PM_COUNT = 2'd2    // pacing in progress
    } pace_mode_e;

    function automatic pace_mode_e pace_mode(input logic wr, input logic cont,
                                             input logic active);
        if (wr || !cont)
            return PM_CLEAR;
        else if (!active)
            return PM_HOLD;
        else
            return PM_COUNT;
    endfunction

endpackage

// File: rtl/pace_div_regs.sv
module pace_div_regs #(
    parameter int INT_W  = pace_div_pkg::PACE_INT_W_DEF,
    parameter int FRAC_W = pace_div_pkg::PACE_FRAC_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [INT_W-1:0]  wr_int,
    input  logic [FRAC_W-1:0] wr_frac,
    output logic [INT_W-1:0]  int_q,
    output logic [FRAC_W-1:0] frac_q,
    output logic              active
);

    always_ff @(posedge clk) begin
        if (rst) begin
            int_q  <= '0;
            frac_q <= '0;
        end else if (wr) begin
            int_q  <= wr_int;
            frac_q <= wr_frac;
        end
    end

    assign active = (int_q != '0) || (frac_q != '0);

endmodule

// File: rtl/pace_dither.sv
module pace_dither #(
    parameter int FRAC_W = pace_div_pkg::PACE_FRAC_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              advance,
    input  logic [FRAC_W-1:0] frac,
    output logic              carry
);

    localparam int SUM_W = FRAC_W + 1;

    logic [FRAC_W-1:0] phase_q;
    logic [SUM_W-1:0]  sum;

    // Carry of the pending addition decides the length of the current period
    assign sum   = {1'b0, phase_q} + {1'b0, frac};
    assign carry = sum[SUM_W-1];

    always_ff @(posedge clk) begin
        if (rst || clear)
            phase_q <= '0;
        else if (advance)
            phase_q <= sum[FRAC_W-1:0];
    end

endmodule

// File: rtl/pace_counter.sv
module pace_counter #(
    parameter int INT_W = pace_div_pkg::PACE_INT_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  pace_div_pkg::pace_mode_e mode,
    input  logic [INT_W-1:0]        int_val,
    input  logic                    extend,
    output logic                    period_end,
    output logic                    tick_q
);
    import pace_div_pkg::*;

    localparam int CNT_W = INT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    // Last count value of this period: INT, or INT+1 when dithered longer
    assign last       = {1'b0, int_val} + {{INT_W{1'b0}}, extend};
    assign period_end = (mode == PM_COUNT) && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            unique case (mode)
                PM_COUNT: begin
                    if (period_end) begin
                        cnt_q  <= '0;
                        tick_q <= 1'b1;
                    end else begin
                        cnt_q  <= cnt_q + CNT_W'(1);
                        tick_q <= 1'b0;
                    end
                end
                default: begin
                    cnt_q  <= '0;
                    tick_q <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/pace_div.sv
module pace_div #(
    parameter int INT_W  = pace_div_pkg::PACE_INT_W_DEF,
    parameter int FRAC_W = pace_div_pkg::PACE_FRAC_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cont_en,
    input  logic              div_wr,
    input  logic [INT_W-1:0]  div_int_in,
    input  logic [FRAC_W-1:0] div_frac_in,
    output logic              tick,
    output logic              pace_active
);
    import pace_div_pkg::*;

    logic [INT_W-1:0]  div_int_q;
    logic [FRAC_W-1:0] div_frac_q;
    logic              carry;
    logic              period_end;
    pace_mode_e        mode;

    pace_div_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (div_wr),
        .wr_int  (div_int_in),
        .wr_frac (div_frac_in),
        .int_q   (div_int_q),
        .frac_q  (div_frac_q),
        .active  (pace_active)
    );

    assign mode = pace_mode(div_wr, cont_en, pace_active);

    pace_dither #(.FRAC_W(FRAC_W)) u_dither (
        .clk     (clk),
        .rst     (rst),
        .clear   (mode == PM_CLEAR),
        .advance (period_end),
        .frac    (div_frac_q),
        .carry   (carry)
    );

    pace_counter #(.INT_W(INT_W)) u_count (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .int_val    (div_int_q),
        .extend     (carry),
        .period_end (period_end),
        .tick_q     (tick)
    );

endmodule

// File: rtl/pace_div_chk.sv
module pace_div_chk #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cont_en,
    input logic              div_wr,
    input logic [INT_W-1:0]  div_int_in,
    input logic [FRAC_W-1:0] div_frac_in,
    input logic [INT_W-1:0]  div_int_q,
    input logic              tick,
    input logic              pace_active
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!tick && !pace_active));

    a_r2_active_load: assert property (@(posedge clk) disable iff (rst)
        div_wr |=> (pace_active == (($past(div_int_in) != '0) || ($past(div_frac_in) != '0))));

    a_r3_idle_no_tick: assert property (@(posedge clk) disable iff (rst)
        !pace_active |-> !tick);

    a_r7_write_no_tick: assert property (@(posedge clk) disable iff (rst)
        div_wr |=> !tick);

    a_r8_off_no_tick: assert property (@(posedge clk) disable iff (rst)
        !cont_en |=> !tick);

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (tick && div_int_q != '0 && !div_wr) |=> !tick);

endmodule

bind pace_div pace_div_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cont_en     (cont_en),
    .div_wr      (div_wr),
    .div_int_in  (div_int_in),
    .div_frac_in (div_frac_in),
    .div_int_q   (div_int_q),
    .tick        (tick),
    .pace_active (pace_active)
);

// File: tb/tb_pace_div.sv
module tb_pace_div;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cont_en;
    logic        div_wr;
    logic [15:0] div_int_in;
    logic [7:0]  div_frac_in;
    logic        tick;
    logic        pace_active;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pace_div dut (
        .clk         (clk),
        .rst         (rst),
        .cont_en     (cont_en),
        .div_wr      (div_wr),
        .div_int_in  (div_int_in),
        .div_frac_in (div_frac_in),
        .tick        (tick),
        .pace_active (pace_active)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Loads a divisor with continuous mode off, then enables pacing.
    task automatic program_div(input int iv, input int fv);
        @(negedge clk);
        cont_en     = 1'b0;
        div_wr      = 1'b1;
        div_int_in  = 16'(iv);
        div_frac_in = 8'(fv);
        @(negedge clk);
        div_wr  = 1'b0;
        cont_en = 1'b1;
    endtask

    // Samples after each edge until a tick, returns the number of samples.
    task automatic count_until_tick(input int limit, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick && n < limit);
    endtask

    // Compares every sample against the dither model for nper periods.
    task automatic run_pattern(input string req, input int iv, input int fv,
                               input int nper, output int last_idx);
        int acc = 0, nxt, got = 0, mism = 0, c;
        int first_i = -1, first_a = 0, first_e = 0;
        c       = ((acc + fv) >= 256) ? 1 : 0;
        acc     = (acc + fv) % 256;
        nxt     = 1 + iv + c;
        last_idx = 0;
        program_div(iv, fv);
        for (int i = 1; got < nper; i++) begin
            bit e;
            @(negedge clk);
            e = (i == nxt);
            if (tick != e) begin
                mism++;
                if (first_i < 0) begin first_i = i; first_a = tick; first_e = e; end
            end
            if (e) begin
                got++;
                last_idx = i;
                c   = ((acc + fv) >= 256) ? 1 : 0;
                acc = (acc + fv) % 256;
                nxt = nxt + 1 + iv + c;
            end
        end
        if (mism != 0)
            $display("FAIL %s first mismatch at sample %0d: actual=%0d expected=%0d",
                     req, first_i, first_a, first_e);
        check(req, "tick pattern mismatches", mism, 0);
        cont_en = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; cont_en = 1'b0; div_wr = 1'b0; div_int_in = '0; div_frac_in = '0;
        repeat (3) @(negedge clk);
        check("R1", "tick in reset", tick, 0);
        check("R1", "active in reset", pace_active, 0);
        rst = 1'b0;
        cont_en = 1'b1;
        @(negedge clk);
        check("R1", "active after reset", pace_active, 0);
        check("R1", "tick after reset", tick, 0);
        cont_en = 1'b0;
    endtask

    task automatic t_zero_div();
        int seen = 0;
        program_div(5, 0);
        check("R2", "active with INT=5", pace_active, 1);
        program_div(0, 1);
        check("R2", "active with FRAC=1", pace_active, 1);
        program_div(0, 0);
        check("R2", "active with zero divisor", pace_active, 0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tick) seen++;
        end
        check("R3", "ticks with zero divisor", seen, 0);
        cont_en = 1'b0;
    endtask

    task automatic t_fixed();
        int last;
        int n;
        run_pattern("R4", 3, 0, 6, last);
        check("R4", "sixth tick index INT=3", last, 24);
        program_div(2, 64);
        count_until_tick(50, n);
        check("R4", "first period INT=2 FRAC=0x40", n, 3);
        cont_en = 1'b0;
        run_pattern("R4", 2, 64, 12, last);
    endtask

    task automatic t_half();
        int n;
        run_pattern("R5", 0, 128, 10, n);
        program_div(0, 128);
        count_until_tick(10, n);
        check("R5", "first interval", n, 1);
        count_until_tick(10, n);
        check("R5", "second interval", n, 2);
        count_until_tick(10, n);
        check("R5", "third interval", n, 1);
        cont_en = 1'b0;
    endtask

    task automatic t_average();
        int last;
        run_pattern("R6", 2, 53, 256, last);
        check("R6", "span of 256 periods", last, 256 * 3 + 53);
        run_pattern("R6", 0, 255, 256, last);
        check("R6", "span FRAC=0xFF", last, 256 + 255);
    endtask

    task automatic t_restart();
        int n;
        program_div(5, 0);
        repeat (3) @(negedge clk);
        div_wr = 1'b1;
        @(negedge clk);
        check("R7", "tick on write cycle", tick, 0);
        div_wr = 1'b0;
        count_until_tick(20, n);
        check("R7", "period after rewrite", n, 6);
        cont_en = 1'b0;
        // accumulator restart: INT=1 FRAC=0x80 gives 2,3,2,3 from phase zero
        program_div(1, 128);
        count_until_tick(20, n);
        check("R7", "first period before rewrite", n, 2);
        div_wr = 1'b1;
        @(negedge clk);
        div_wr = 1'b0;
        count_until_tick(20, n);
        check("R7", "first period after rewrite", n, 2);
        count_until_tick(20, n);
        check("R7", "second period after rewrite", n, 3);
        cont_en = 1'b0;
    endtask

    task automatic t_cont_off();
        int n;
        int seen = 0;
        program_div(4, 128);
        count_until_tick(20, n);
        check("R8", "first period", n, 5);
        cont_en = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (tick) seen++;
        end
        check("R8", "ticks while mode off", seen, 0);
        cont_en = 1'b1;
        count_until_tick(20, n);
        check("R8", "first period after re-enable", n, 5);
        count_until_tick(20, n);
        check("R8", "second period after re-enable", n, 6);
        cont_en = 1'b0;
    endtask

    task automatic t_large();
        int last;
        run_pattern("R9", 1000, 0, 3, last);
        check("R9", "third tick at INT=1000", last, 3003);
    endtask

    task automatic t_gap();
        int pairs = 0;
        bit prev  = 0;
        program_div(1, 255);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (tick && prev) pairs++;
            prev = tick;
        end
        check("R10", "back-to-back ticks with INT=1", pairs, 0);
        cont_en = 1'b0;
    endtask

    initial begin
        t_reset();
        t_zero_div();
        t_fixed();
        t_half();
        t_average();
        t_restart();
        t_cont_off();
        t_large();
        t_gap();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule